// File: doc/BRIEF.md
# Bulk Erase Verify Sequencer

This controller sits on the host side of a byte-wide flash array and carries out a complete chip erase with blank checking. When started, it opens an erase pulse with a two-write erase command. It then waits for a programmable number of clock cycles. After that it closes the pulse with an erase-verify write that also latches the address of the byte to be examined, and it reads that byte back.

A byte counts as blank only when it returns FFh. On any other value the sequencer opens a new erase pulse. It then continues verification at the byte that failed instead of starting over. When the highest address reads blank, it returns the array to read mode and reports completion. If a byte is still not blank after the configured maximum number of pulses, the sequencer gives up and reports failure.

The bus is modelled as single-cycle strobes. A write cycle drives `busWr` with address and data. A read cycle drives `busRd` with an address, and the array returns the data on `busRdata` in the following cycle.

Top module: `erase_verify_seq`

## Requirements
- R1: During and right after reset, `done`, `fail`, `busWr` and `busRd` are low and the sequencer is idle.
- R2: Every erase pulse is opened by two write cycles of 20h on consecutive clock cycles, the second of which starts the pulse.
- R3: The erase-verify write (data A0h) that ends a pulse comes exactly `pulseCycles`+2 clock cycles after the second 20h write.
- R4: Before each byte is checked, a write of A0h carrying that byte's address is issued, and the read of that same address follows in the very next cycle.
- R5: A byte passes only if the read data is FFh; any other value causes a new erase pulse.
- R6: After a re-erase, the first verify address is the address that failed, not address 0.
- R7: When address 2^ADDR_W-1 reads FFh, the sequencer writes FFh (read-array command) and then raises `done`.
- R8: If a byte reads non-FFh after `maxPulses` pulses have been issued, `fail` rises and no further bus cycle is issued; `maxPulses` must be at least 1.
- R9: `done` and `fail` stay high until the next `start`, which clears them and begins a new erase.
- R10: `busWr` and `busRd` are never high in the same cycle, and `done` and `fail` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a bulk erase |
| pulseCycles | input | CNT_W | Hold cycles inside each erase pulse |
| maxPulses | input | PULSE_W | Largest number of erase pulses allowed |
| busWr | output | 1 | Write cycle strobe |
| busRd | output | 1 | Read cycle strobe |
| busAddr | output | ADDR_W | Bus address (current verify address) |
| busWdata | output | 8 | Write data / command byte |
| busRdata | input | 8 | Read data, valid the cycle after `busRd` |
| done | output | 1 | Erase finished, whole array blank |
| fail | output | 1 | Erase abandoned, pulse limit reached |

## Verification
The hardest situation to reach is a re-erase in the middle of the array. That case needs a byte that stays non-blank for more pulses than the bytes before it, so that resumption at a non-zero address can be observed. The bench's array model gives each byte its own count of pulses it needs before it reads FFh. It draws these counts at random and also sets them directly: a late byte needing several pulses, and a limit equal to or one below the largest count. This covers both the resume path and the pass/fail boundary.

// File: rtl/ersv_pkg.sv
package ersv_pkg;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_EVERIFY = 8'hA0;
  localparam logic [7:0] CMD_READ    = 8'hFF;
  localparam logic [7:0] BLANK_BYTE  = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_CONFIRM, S_HOLD, S_VCMD,
    S_VREAD, S_CHECK, S_EXIT, S_DONE, S_FAIL
  } seqState_t;

  typedef struct packed {
    logic clrAll;
    logic incPulse;
    logic loadHold;
    logic decHold;
    logic incAddr;
  } dpCtl_t;
endpackage

// File: rtl/ersv_datapath.sv
module ersv_datapath
  import ersv_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int CNT_W   = 8,
  parameter int PULSE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dpCtl_t             ctl,
  input  logic [CNT_W-1:0]   pulseCycles,
  input  logic [PULSE_W-1:0] maxPulses,
  output logic [ADDR_W-1:0]  curAddr,
  output logic               holdZero,
  output logic               lastAddr,
  output logic               pulseLimit
);
  localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

  logic [PULSE_W-1:0] pulseCnt;
  logic [CNT_W-1:0]   holdCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curAddr  <= '0;
      pulseCnt <= '0;
      holdCnt  <= '0;
    end else begin
      if (ctl.clrAll) begin
        curAddr  <= '0;
        pulseCnt <= '0;
      end else begin
        if (ctl.incPulse) pulseCnt <= pulseCnt + PULSE_W'(1);
        if (ctl.incAddr)  curAddr  <= curAddr + ADDR_W'(1);
      end
      if (ctl.loadHold)     holdCnt <= pulseCycles;
      else if (ctl.decHold) holdCnt <= holdCnt - CNT_W'(1);
    end
  end

  assign holdZero   = (holdCnt == '0);
  assign lastAddr   = (curAddr == ADDR_MAX);
  assign pulseLimit = (pulseCnt >= maxPulses);

  AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.incPulse && pulseCnt != '0) |-> (pulseCnt < maxPulses)); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ctl.clrAll) && curAddr != $past(curAddr)) |-> (curAddr == $past(curAddr) + ADDR_W'(1))); // R6
  AST_HOLD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.decHold |-> !holdZero); // R3
endmodule

// File: rtl/ersv_ctrl.sv
module ersv_ctrl
  import ersv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] busRdata,
  input  logic       holdZero,
  input  logic       lastAddr,
  input  logic       pulseLimit,
  output dpCtl_t     ctl,
  output logic       busWr,
  output logic       busRd,
  output logic [7:0] busWdata,
  output logic       done,
  output logic       fail
);
  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    busWr     = 1'b0;
    busRd     = 1'b0;
    busWdata  = 8'h00;
    unique case (state)
      S_IDLE, S_DONE, S_FAIL: begin
        if (start) begin
          ctl.clrAll = 1'b1;
          nextState  = S_SETUP;
        end
      end
      S_SETUP: begin
        busWr     = 1'b1;
        busWdata  = CMD_ERASE;
        nextState = S_CONFIRM;
      end
      S_CONFIRM: begin
        busWr        = 1'b1;
        busWdata     = CMD_ERASE;
        ctl.incPulse = 1'b1;
        ctl.loadHold = 1'b1;
        nextState    = S_HOLD;
      end
      S_HOLD: begin
        if (holdZero) nextState   = S_VCMD;
        else          ctl.decHold = 1'b1;
      end
      S_VCMD: begin
        busWr     = 1'b1;
        busWdata  = CMD_EVERIFY;
        nextState = S_VREAD;
      end
      S_VREAD: begin
        busRd     = 1'b1;
        nextState = S_CHECK;
      end
      S_CHECK: begin
        if (busRdata == BLANK_BYTE) begin
          if (lastAddr) nextState = S_EXIT;
          else begin
            ctl.incAddr = 1'b1;
            nextState   = S_VCMD;
          end
        end else if (pulseLimit) nextState = S_FAIL;
        else                     nextState = S_SETUP;
      end
      S_EXIT: begin
        busWr     = 1'b1;
        busWdata  = CMD_READ;
        nextState = S_DONE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign done = (state == S_DONE);
  assign fail = (state == S_FAIL);

  AST_NO_BUS_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(busWr && busRd)); // R10
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail)); // R10
  AST_READ_AFTER_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
    busRd |-> ($past(busWr) && $past(busWdata) == CMD_EVERIFY)); // R4
  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!busWr && !busRd)); // R8
  AST_DONE_AFTER_READCMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busWr) && $past(busWdata) == CMD_READ)); // R7
endmodule

// File: rtl/erase_verify_seq.sv
module erase_verify_seq
  import ersv_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int CNT_W   = 8,
  parameter int PULSE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CNT_W-1:0]   pulseCycles,
  input  logic [PULSE_W-1:0] maxPulses,
  output logic               busWr,
  output logic               busRd,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [7:0]         busWdata,
  input  logic [7:0]         busRdata,
  output logic               done,
  output logic               fail
);
  dpCtl_t ctl;
  logic   holdZero, lastAddr, pulseLimit;

  ersv_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busRdata(busRdata),
    .holdZero(holdZero), .lastAddr(lastAddr), .pulseLimit(pulseLimit),
    .ctl(ctl), .busWr(busWr), .busRd(busRd), .busWdata(busWdata),
    .done(done), .fail(fail)
  );

  ersv_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PULSE_W(PULSE_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .pulseCycles(pulseCycles),
    .maxPulses(maxPulses), .curAddr(busAddr), .holdZero(holdZero),
    .lastAddr(lastAddr), .pulseLimit(pulseLimit)
  );
endmodule

// File: tb/test_erase_verify_seq.sv
module test_erase_verify_seq;
  localparam int ADDR_W = 4, CNT_W = 8, PULSE_W = 6;
  localparam int NB = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CNT_W-1:0] pulseCycles = '0;
  logic [PULSE_W-1:0] maxPulses = 6'd1;
  logic busWr, busRd, done, fail;
  logic [ADDR_W-1:0] busAddr;
  logic [7:0] busWdata, busRdata = 8'h00;

  erase_verify_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PULSE_W(PULSE_W)) i_erase_verify_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pulseCycles(pulseCycles),
    .maxPulses(maxPulses), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .done(done), .fail(fail)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int need [NB];
  // array model state
  int pulses, setupCyc, confirmCyc, verifies, lastFail, wrAfterEnd;
  bit setupPending, firstAfter, prevA0, readCmdSeen;
  logic [ADDR_W-1:0] latched;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // array model, sampled mid-cycle
  always @(negedge clk) begin
    bit wasA0;
    wasA0 = prevA0;
    prevA0 = 1'b0;
    if (rst_n && busWr) begin
      if (done || fail) wrAfterEnd++;
      case (busWdata)
        8'h20: if (setupPending) begin
                 check(setupCyc == cyc - 1, "R2", cyc - setupCyc, 1);
                 pulses++; setupPending = 1'b0; confirmCyc = cyc; firstAfter = 1'b1;
               end else begin
                 setupPending = 1'b1; setupCyc = cyc;
               end
        8'hA0: begin
                 verifies++; latched = busAddr; prevA0 = 1'b1;
                 if (firstAfter) begin
                   check(cyc - confirmCyc == int'(pulseCycles) + 2, "R3",
                         cyc - confirmCyc, int'(pulseCycles) + 2);
                   if (pulses > 1)
                     check(int'(busAddr) == lastFail, "R6", int'(busAddr), lastFail);
                   else
                     check(busAddr == '0, "R6", int'(busAddr), 0);
                   firstAfter = 1'b0;
                 end
               end
        8'hFF: readCmdSeen = 1'b1;
        default: check(1'b0, "R2", int'(busWdata), 32);
      endcase
    end
    if (rst_n && busRd) begin
      if (done || fail) wrAfterEnd++;
      check(wasA0 && busAddr == latched, "R4", int'(busAddr), int'(latched));
      if (pulses >= need[busAddr]) busRdata <= 8'hFF;
      else begin
        busRdata <= 8'($urandom_range(0, 254));
        lastFail = int'(busAddr);
      end
    end
    if (rst_n) check(!(busWr && busRd) && !(done && fail), "R10", int'(busWr & busRd), 0);
  end

  // expected behaviour derived from the requirements
  function automatic void expectRun(input int maxP, output int expPulses,
                                    output int expVerifies, output bit expPass);
    int a = 0, p = 1, n = 0;
    expPass = 1'b0;
    forever begin
      n++;
      if (p >= need[a]) begin
        if (a == NB - 1) begin expPass = 1'b1; break; end
        a++;
      end else begin
        if (p >= maxP) break;
        p++;
      end
    end
    expPulses = p; expVerifies = n;
  endfunction

  task automatic runCase(input int p, input int maxP);
    int ep, ev, t;
    bit pass;
    expectRun(maxP, ep, ev, pass);
    @(negedge clk);
    pulses = 0; verifies = 0; lastFail = -1; wrAfterEnd = 0;
    setupPending = 0; firstAfter = 0; readCmdSeen = 0;
    pulseCycles = CNT_W'(p); maxPulses = PULSE_W'(maxP);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!done && !fail, "R9", int'(done | fail), 0);
    t = 0;
    while (!(done || fail) && t < 6000) begin @(negedge clk); t++; end
    check(t < 6000, "R7", t, 6000);
    check(done == pass, "R7", int'(done), int'(pass));
    check(fail == !pass, "R8", int'(fail), int'(!pass));
    check(pulses == ep, "R5", pulses, ep);
    check(verifies == ev, "R6", verifies, ev);
    check(readCmdSeen == pass, "R7", int'(readCmdSeen), int'(pass));
    repeat (12) @(negedge clk);
    check(done == pass && fail == !pass, "R9", int'(done), int'(pass));
    check(wrAfterEnd == 0, "R8", wrAfterEnd, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NB; i++) need[i] = 1;
    repeat (3) @(negedge clk);
    check(!done && !fail && !busWr && !busRd, "R1", int'(done | fail | busWr | busRd), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!done && !fail && !busWr && !busRd, "R1", int'(done | fail | busWr | busRd), 0);

    runCase(0, 4);                                  // all blank after one pulse
    for (int i = 0; i < NB; i++) need[i] = 1;
    need[NB-1] = 3; need[9] = 2;
    runCase(5, 3);                                  // limit equals need: pass, resume mid-array
    for (int i = 0; i < NB; i++) need[i] = 1;
    need[0] = 4;
    runCase(1, 3);                                  // one short of need: fail at address 0
    for (int i = 0; i < NB; i++) need[i] = 1;
    need[7] = 2;
    runCase(2, 1);                                  // single pulse allowed, fails mid-array
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < NB; i++) need[i] = $urandom_range(1, 4);
      runCase($urandom_range(0, 7), $urandom_range(1, 5));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule